// File: doc/BRIEF.md
# Calendar Clock with Announced Update Window

This block keeps time of day and date. It has second, minute, hour, day-of-week, day-of-month, month and two-digit year counters, and it moves forward by one second for each one-cycle pulse on its tick input. A processor reads and writes the counters and a small set of control and status registers through a byte-wide port that selects a register by index.

A tick does not advance the time at once. It starts a timed update window. An update-in-progress status bit rises first, which gives software a lead time before the counters change. After the window the whole calendar steps by one second in a single cycle, and the status bit falls.

Software chooses BCD or binary encoding, and 12-hour or 24-hour hours, through control bits. The counters always hold plain binary, and conversion happens at the port, so a change of mode takes effect on the next read. A set bit stops all updates while software loads a new time. When an update finishes, a flag is raised, and this flag can drive an interrupt output.

Top module: `cal_clock`

## Requirements
- R1: Register index map: 0 seconds, 2 minutes, 4 hours, 6 day of week, 7 day of month, 8 month, 9 year, 10 control A, 11 control B, 12 flags C, 13 status D. After reset the time is 00:00:00 with day of week 1, day 1, month 1, year 00. Control B reads 0x02, which is BCD and 24-hour.
- R2: A tick pulse with set clear raises update-in-progress, which is bit 7 of index 10, on the next cycle. The bit stays high for LEAD_CYC+BUSY_CYC cycles. When it falls, the time has advanced by exactly one second.
- R3: Time reads taken while update-in-progress is high return the value from before the update.
- R4: A write to a time index (0, 2, 4, 6, 7, 8, 9) while update-in-progress is high and set is clear is ignored.
- R5: Set, which is bit 7 of index 11, blocks any update from starting. Raising set aborts a pending window without advancing the time. While set is high, time writes are accepted.
- R6: Bit 2 of index 11 selects binary when 1. When it is 0, BCD is used, with tens in bits 7:4 and units in bits 3:0. The selection applies to both reads and writes of every time field.
- R7: Bit 1 of index 11 selects 24-hour hours (0 to 23) when 1. When it is 0, hours are 1 to 12 in bits 6:0 with PM in bit 7. Midnight reads as 12 with PM clear, and noon reads as 12 with PM set.
- R8: Seconds and minutes wrap at 59, and each wrap carries into the next field. Hours wrap at 23 and advance the day. Day of week counts 1 to 7 and then returns to 1.
- R9: Day of month wraps after 28, 29, 30 or 31 according to the month, with 29 days in February when the year is divisible by 4. A wrap of month 12 gives month 1, and year 99 advances to 00.
- R10: Bit 4 of index 12 sets when an update completes, and a read of index 12 clears it. That read still returns the bit as set. Bit 7 of index 12, and the irq output, equal bit 4 ANDed with bit 4 of index 11.
- R11: Index 13 always reads 0x80. Bits 6:0 of index 10 and the bytes at indices 1, 3 and 5 read back what was written. Indices 14 and 15 read 0. Writes to 12 and 13 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| reg_addr | input | 4 | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears flags on index 12) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data, valid the cycle after the index is presented |
| irq | output | 1 | Update-ended interrupt |

## Verification
A wrong window state shows up as a status bit 7 at index 10 that rises late, or that stays high too long or too short. Such a fault also shows as time that moves while the bit is still high, and the bench catches it within one window of about LEAD_CYC+BUSY_CYC cycles. A fault in the carry chain or the month-length logic appears only at the boundary it affects. For that reason the stimulus loads times that sit one second before the wraps of minute, hour, day, month and year, in every encoding and hour mode. The result is read back right after the single update that crosses the boundary. Write gating and the set-bit abort are checked by reading the seconds after the window: a wrong gate leaves the written or advanced value in place.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
    logic [2:0] dow;
    logic [4:0] dom;
    logic [3:0] mon;
    logic [6:0] year;
  } cal_time_t;

  typedef enum logic [1:0] {UPD_IDLE, UPD_LEAD, UPD_BUSY} upd_state_e;

  localparam int NFIELD = 7;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DOM  = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  localparam logic [3:0] IX_SEC  = 4'd0;
  localparam logic [3:0] IX_ASEC = 4'd1;
  localparam logic [3:0] IX_MIN  = 4'd2;
  localparam logic [3:0] IX_AMIN = 4'd3;
  localparam logic [3:0] IX_HOUR = 4'd4;
  localparam logic [3:0] IX_AHR  = 4'd5;
  localparam logic [3:0] IX_DOW  = 4'd6;
  localparam logic [3:0] IX_DOM  = 4'd7;
  localparam logic [3:0] IX_MON  = 4'd8;
  localparam logic [3:0] IX_YEAR = 4'd9;
  localparam logic [3:0] IX_CTLA = 4'd10;
  localparam logic [3:0] IX_CTLB = 4'd11;
  localparam logic [3:0] IX_FLAG = 4'd12;
  localparam logic [3:0] IX_STAT = 4'd13;

  localparam cal_time_t TIME_RESET = '{sec: 6'd0, min: 6'd0, hour: 5'd0,
                                       dow: 3'd1, dom: 5'd1, mon: 4'd1, year: 7'd0};

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [3:0] tens, units;
    tens  = 4'(v / 7'd10);
    units = 4'(v % 7'd10);
    return {tens, units};
  endfunction

  function automatic logic [6:0] from_bcd(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] enc_byte(input logic [6:0] v, input logic bin);
    return bin ? {1'b0, v} : to_bcd(v);
  endfunction

  function automatic logic [6:0] dec_byte(input logic [7:0] b, input logic bin);
    return bin ? b[6:0] : from_bcd(b);
  endfunction

  function automatic logic [7:0] hour_enc(input logic [4:0] h, input logic bin, input logic h24);
    logic [7:0] r;
    logic [4:0] h12;
    if (h24) begin
      r = enc_byte(7'(h), bin);
    end else begin
      h12 = (h >= 5'd12) ? h - 5'd12 : h;
      if (h12 == 5'd0) h12 = 5'd12;
      r = enc_byte(7'(h12), bin);
      r[7] = (h >= 5'd12);
    end
    return r;
  endfunction

  function automatic logic [4:0] hour_dec(input logic [7:0] b, input logic bin, input logic h24);
    logic [6:0] v;
    if (h24) return 5'(dec_byte(b, bin));
    v = dec_byte({1'b0, b[6:0]}, bin);
    if (v == 7'd12) return b[7] ? 5'd12 : 5'd0;
    return b[7] ? 5'(v + 7'd12) : 5'(v);
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [6:0] year);
    case (mon)
      4'd2:                      return (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/cal_upd_timer.sv
module cal_upd_timer
  import cal_pkg::*;
#(
  parameter int LEAD_CYC = 8,
  parameter int BUSY_CYC = 65
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic inhibit,
  output logic uip,
  output logic adv
);
  localparam int MAXC = (LEAD_CYC > BUSY_CYC) ? LEAD_CYC : BUSY_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  upd_state_e      st;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (rst || inhibit) begin
      st  <= UPD_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        UPD_IDLE: if (tick) begin
          st  <= UPD_LEAD;
          cnt <= CW'(LEAD_CYC - 1);
        end
        UPD_LEAD: if (cnt == '0) begin
          st  <= UPD_BUSY;
          cnt <= CW'(BUSY_CYC - 1);
        end else cnt <= cnt - 1'b1;
        UPD_BUSY: if (cnt == '0) st <= UPD_IDLE;
                  else cnt <= cnt - 1'b1;
        default:  st <= UPD_IDLE;
      endcase
    end
  end

  assign uip = (st != UPD_IDLE);
  assign adv = (st == UPD_BUSY) && (cnt == '0) && !inhibit;

  int uip_run;
  always_ff @(posedge clk) begin
    if (rst) uip_run <= 0;
    else     uip_run <= uip ? uip_run + 1 : 0;
  end

  // R2
  uip_len_chk: assert property (@(posedge clk) disable iff (rst)
    uip_run <= LEAD_CYC + BUSY_CYC);
  // R2
  uip_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(uip) |-> $past(tick));
  // R2
  adv_end_chk: assert property (@(posedge clk) disable iff (rst)
    adv |=> !uip);
  // R5
  inhibit_abort_chk: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> !uip);

endmodule

// File: rtl/cal_counters.sv
module cal_counters
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [NFIELD-1:0] we,
  input  cal_time_t         wd,
  output cal_time_t         now
);
  cal_time_t nxt;

  always_comb begin
    nxt = now;
    if (now.sec >= 6'd59) begin
      nxt.sec = 6'd0;
      if (now.min >= 6'd59) begin
        nxt.min = 6'd0;
        if (now.hour >= 5'd23) begin
          nxt.hour = 5'd0;
          nxt.dow  = (now.dow >= 3'd7) ? 3'd1 : now.dow + 3'd1;
          if (now.dom >= month_days(now.mon, now.year)) begin
            nxt.dom = 5'd1;
            if (now.mon >= 4'd12) begin
              nxt.mon  = 4'd1;
              nxt.year = (now.year >= 7'd99) ? 7'd0 : now.year + 7'd1;
            end else nxt.mon = now.mon + 4'd1;
          end else nxt.dom = now.dom + 5'd1;
        end else nxt.hour = now.hour + 5'd1;
      end else nxt.min = now.min + 6'd1;
    end else nxt.sec = now.sec + 6'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) now <= TIME_RESET;
    else if (|we) begin
      if (we[F_SEC])  now.sec  <= wd.sec;
      if (we[F_MIN])  now.min  <= wd.min;
      if (we[F_HOUR]) now.hour <= wd.hour;
      if (we[F_DOW])  now.dow  <= wd.dow;
      if (we[F_DOM])  now.dom  <= wd.dom;
      if (we[F_MON])  now.mon  <= wd.mon;
      if (we[F_YEAR]) now.year <= wd.year;
    end else if (adv) now <= nxt;
  end

  // R9
  year_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(now.year) && !$past(we[F_YEAR])) |-> $past(now.mon) >= 4'd12);
  // R8
  dow_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(now.dow) && !$past(we[F_DOW])) |-> $past(now.hour) >= 5'd23);

endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
#(
  parameter int LEAD_CYC = 8,
  parameter int BUSY_CYC = 65
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_1hz,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  logic [6:0] ctla_lo;
  logic [7:0] ctlb;
  logic [7:0] alm_sec, alm_min, alm_hr;
  logic       uf_q;
  logic       uip, adv;
  logic [NFIELD-1:0] we;
  cal_time_t  wd, now;
  logic [7:0] rview;

  wire set_bit = ctlb[7];
  wire bin     = ctlb[2];
  wire h24     = ctlb[1];
  wire time_ok = set_bit || !uip;

  cal_upd_timer #(.LEAD_CYC(LEAD_CYC), .BUSY_CYC(BUSY_CYC)) u_timer (
    .clk(clk), .rst(rst), .tick(tick_1hz), .inhibit(set_bit),
    .uip(uip), .adv(adv));

  always_comb begin
    wd.sec  = 6'(dec_byte(reg_wdata, bin));
    wd.min  = 6'(dec_byte(reg_wdata, bin));
    wd.hour = hour_dec(reg_wdata, bin, h24);
    wd.dow  = 3'(dec_byte(reg_wdata, bin));
    wd.dom  = 5'(dec_byte(reg_wdata, bin));
    wd.mon  = 4'(dec_byte(reg_wdata, bin));
    wd.year = dec_byte(reg_wdata, bin);
    we = '0;
    if (reg_wr && time_ok) begin
      case (reg_addr)
        IX_SEC:  we[F_SEC]  = 1'b1;
        IX_MIN:  we[F_MIN]  = 1'b1;
        IX_HOUR: we[F_HOUR] = 1'b1;
        IX_DOW:  we[F_DOW]  = 1'b1;
        IX_DOM:  we[F_DOM]  = 1'b1;
        IX_MON:  we[F_MON]  = 1'b1;
        IX_YEAR: we[F_YEAR] = 1'b1;
        default: we = '0;
      endcase
    end
  end

  cal_counters u_cnt (
    .clk(clk), .rst(rst), .adv(adv), .we(we), .wd(wd), .now(now));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctla_lo <= '0;
      ctlb    <= 8'h02;
      alm_sec <= '0;
      alm_min <= '0;
      alm_hr  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        IX_CTLA: ctla_lo <= reg_wdata[6:0];
        IX_CTLB: ctlb    <= reg_wdata;
        IX_ASEC: alm_sec <= reg_wdata;
        IX_AMIN: alm_min <= reg_wdata;
        IX_AHR:  alm_hr  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                uf_q <= 1'b0;
    else if (adv)                           uf_q <= 1'b1;
    else if (reg_rd && reg_addr == IX_FLAG) uf_q <= 1'b0;
  end

  always_comb begin
    case (reg_addr)
      IX_SEC:  rview = enc_byte(7'(now.sec), bin);
      IX_MIN:  rview = enc_byte(7'(now.min), bin);
      IX_HOUR: rview = hour_enc(now.hour, bin, h24);
      IX_DOW:  rview = enc_byte(7'(now.dow), bin);
      IX_DOM:  rview = enc_byte(7'(now.dom), bin);
      IX_MON:  rview = enc_byte(7'(now.mon), bin);
      IX_YEAR: rview = enc_byte(now.year, bin);
      IX_ASEC: rview = alm_sec;
      IX_AMIN: rview = alm_min;
      IX_AHR:  rview = alm_hr;
      IX_CTLA: rview = {uip, ctla_lo};
      IX_CTLB: rview = ctlb;
      IX_FLAG: rview = {uf_q & ctlb[4], 2'b00, uf_q, 4'b0000};
      IX_STAT: rview = 8'h80;
      default: rview = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= 8'h00;
    else     reg_rdata <= rview;
  end

  assign irq = uf_q & ctlb[4];

  // R3
  sec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(now.sec) |-> $past(adv || we[F_SEC]));
  // R4
  wr_block_chk: assert property (@(posedge clk) disable iff (rst)
    (uip && !set_bit) |-> (we == '0));
  // R10
  uf_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(uf_q) |-> $past(adv));

endmodule

// File: tb/cal_clock_bench.sv
module cal_clock_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEAD = 8;
  localparam int BUSY = 65;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_1hz = 1'b0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int m_sec, m_min, m_hour, m_dow, m_dom, m_mon, m_year;
  bit cur_bin, cur_h24, cur_uie;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_clock #(.LEAD_CYC(LEAD), .BUSY_CYC(BUSY)) u_cal_clock (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  function automatic logic [7:0] b_enc(int v, bit bn);
    if (bn) return 8'(v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] b_henc(int h, bit bn, bit h24);
    int h12;
    logic [7:0] r;
    if (h24) return b_enc(h, bn);
    h12 = h % 12;
    if (h12 == 0) h12 = 12;
    r = b_enc(h12, bn);
    if (h >= 12) r[7] = 1'b1;
    return r;
  endfunction

  function automatic int b_dim(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] mode_byte(bit setb);
    return {setb, 2'b00, cur_uie, 1'b0, cur_bin, cur_h24, 1'b0};
  endfunction

  task automatic model_adv();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hour++;
        if (m_hour == 24) begin
          m_hour = 0;
          m_dow = (m_dow == 7) ? 1 : m_dow + 1;
          m_dom++;
          if (m_dom > b_dim(m_mon, m_year)) begin
            m_dom = 1; m_mon++;
            if (m_mon == 13) begin
              m_mon = 1;
              m_year = (m_year == 99) ? 0 : m_year + 1;
            end
          end
        end
      end
    end
  endtask

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic wait_update(output int polls);
    logic [7:0] a;
    polls = 0;
    a = 8'h80;
    while (a[7] && polls < 500) begin
      rd(4'd10, a);
      polls++;
    end
  endtask

  task automatic load_time();
    wr(4'd11, mode_byte(1));
    wr(4'd0, b_enc(m_sec, cur_bin));
    wr(4'd2, b_enc(m_min, cur_bin));
    wr(4'd4, b_henc(m_hour, cur_bin, cur_h24));
    wr(4'd6, b_enc(m_dow, cur_bin));
    wr(4'd7, b_enc(m_dom, cur_bin));
    wr(4'd8, b_enc(m_mon, cur_bin));
    wr(4'd9, b_enc(m_year, cur_bin));
    wr(4'd11, mode_byte(0));
  endtask

  task automatic check_all(string req);
    logic [7:0] d;
    rd(4'd0, d); chk(req, d, b_enc(m_sec, cur_bin));
    rd(4'd2, d); chk(req, d, b_enc(m_min, cur_bin));
    rd(4'd4, d); chk(req, d, b_henc(m_hour, cur_bin, cur_h24));
    rd(4'd6, d); chk(req, d, b_enc(m_dow, cur_bin));
    rd(4'd7, d); chk(req, d, b_enc(m_dom, cur_bin));
    rd(4'd8, d); chk(req, d, b_enc(m_mon, cur_bin));
    rd(4'd9, d); chk(req, d, b_enc(m_year, cur_bin));
  endtask

  task automatic step_and_check(string req);
    int polls;
    pulse_tick();
    wait_update(polls);
    model_adv();
    check_all(req);
  endtask

  task automatic set_case(int s, int mi, int h, int dw, int dm, int mo, int y);
    m_sec = s; m_min = mi; m_hour = h; m_dow = dw; m_dom = dm; m_mon = mo; m_year = y;
    load_time();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    int polls;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_bin = 0; cur_h24 = 1; cur_uie = 0;
    m_sec = 0; m_min = 0; m_hour = 0; m_dow = 1; m_dom = 1; m_mon = 1; m_year = 0;

    // R1 reset state and index map
    check_all("R1");
    rd(4'd11, d); chk("R1 ctlB", d, 8'h02);
    rd(4'd10, d); chk("R1 ctlA", d, 8'h00);
    rd(4'd13, d); chk("R11 stat", d, 8'h80);

    // R2 window: bit rises, lasts LEAD+BUSY cycles, time steps once
    pulse_tick();
    rd(4'd10, d); chk("R2 uip high", {7'd0, d[7]}, 8'h01);
    // R4 write during window ignored; R3 read shows old value
    wr(4'd0, 8'h30);
    rd(4'd0, d); chk("R3 old sec", d, 8'h00);
    wait_update(polls);
    model_adv();
    chk("R2 window length", 8'(polls > (LEAD + BUSY) / 2 - 6 && polls <= (LEAD + BUSY) / 2 + 2), 8'h01);
    check_all("R4 R2");

    // R5 set blocks tick
    wr(4'd11, mode_byte(1));
    pulse_tick();
    rd(4'd10, d); chk("R5 no uip", {7'd0, d[7]}, 8'h00);
    wr(4'd11, mode_byte(0));
    repeat (LEAD + BUSY + 5) @(negedge clk);
    check_all("R5 no step");
    // R5 set aborts pending window
    pulse_tick();
    wr(4'd11, mode_byte(1));
    rd(4'd10, d); chk("R5 abort", {7'd0, d[7]}, 8'h00);
    wr(4'd11, mode_byte(0));
    repeat (LEAD + BUSY + 5) @(negedge clk);
    check_all("R5 abort");

    // R6 BCD and binary carries
    set_case(59, 59, 12, 3, 14, 6, 21);  step_and_check("R6 R8 bcd");
    cur_bin = 1;
    set_case(58, 10, 9, 2, 5, 3, 7);     step_and_check("R6 bin");
    rd(4'd0, d); chk("R6 bin sec", d, 8'h3B);

    // R7 12-hour mode
    cur_bin = 0; cur_h24 = 0;
    set_case(59, 59, 23, 7, 31, 12, 99); step_and_check("R7 R8 R9 midnight");
    rd(4'd4, d); chk("R7 12AM", d, 8'h12);
    set_case(59, 59, 11, 1, 2, 2, 3);    step_and_check("R7 noon");
    rd(4'd4, d); chk("R7 12PM", d, 8'h92);
    set_case(0, 0, 23, 1, 2, 2, 3);      rd(4'd4, d); chk("R7 11PM", d, 8'h91);
    cur_h24 = 1;

    // R9 month lengths
    set_case(59, 59, 23, 4, 28, 2, 1);   step_and_check("R9 feb28");
    set_case(59, 59, 23, 4, 28, 2, 4);   step_and_check("R9 feb leap");
    set_case(59, 59, 23, 4, 29, 2, 4);   step_and_check("R9 feb29");
    set_case(59, 59, 23, 4, 30, 4, 10);  step_and_check("R9 apr30");
    set_case(59, 59, 23, 4, 30, 5, 10);  step_and_check("R9 may30");

    // R10 update-ended flag and irq
    rd(4'd12, d);
    cur_uie = 1;
    wr(4'd11, mode_byte(0));
    pulse_tick(); wait_update(polls); model_adv();
    chk("R10 irq high", 8'(irq), 8'h01);
    rd(4'd12, d); chk("R10 flag", d, 8'h90);
    rd(4'd12, d); chk("R10 cleared", d, 8'h00);
    chk("R10 irq low", 8'(irq), 8'h00);
    cur_uie = 0;
    wr(4'd11, mode_byte(0));
    pulse_tick(); wait_update(polls); model_adv();
    rd(4'd12, d); chk("R10 no irq", d, 8'h10);

    // R11 storage and read-only
    wr(4'd1, 8'h5A); rd(4'd1, d); chk("R11 alm1", d, 8'h5A);
    wr(4'd5, 8'hC3); rd(4'd5, d); chk("R11 alm5", d, 8'hC3);
    wr(4'd10, 8'h26); rd(4'd10, d); chk("R11 ctlA", d, 8'h26);
    wr(4'd13, 8'h00); rd(4'd13, d); chk("R11 stat ro", d, 8'h80);
    wr(4'd12, 8'hFF); rd(4'd12, d); chk("R11 flag ro", d, 8'h00);
    rd(4'd14, d); chk("R11 idx14", d, 8'h00);

    // random mix across modes (R6 R7 R8 R9)
    for (int i = 0; i < 40; i++) begin
      cur_bin = 1'($urandom % 2);
      cur_h24 = 1'($urandom % 2);
      m_year = $urandom % 100;
      m_mon  = 1 + $urandom % 12;
      m_dom  = ($urandom % 2) ? b_dim(m_mon, m_year) : 1 + $urandom % 28;
      m_dow  = 1 + $urandom % 7;
      m_hour = ($urandom % 2) ? 23 : $urandom % 24;
      m_min  = ($urandom % 2) ? 59 : $urandom % 60;
      m_sec  = ($urandom % 3 != 0) ? 59 : $urandom % 60;
      load_time();
      step_and_check("R8 R9 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule